// File: doc/BRIEF.md
# DMA Color Operation Stage

This block sits in the data path of one channel of a memory-to-memory DMA engine, between the read side and the write side. Every element that passes through it can be forwarded unchanged, replaced by a programmed color (constant fill), or dropped from the write stream when it equals a programmed key color (transparent copy). A dropped element still moves down the stream, but its write-enable qualifier is low, so the write side skips that location and keeps its address sequence intact.

Software programs the block through a small register write port:
- a control word holds the two-bit color mode and the element width;
- two 16-bit halves hold the 32-bit color.

The block also reports a four-bit channel-type code that tells the rest of the channel whether it is working as a graphics channel or as a plain 2D channel. The configuration is copied into a working set when a transfer starts. Register writes made while a transfer is running therefore apply only to the next transfer.

Top module: `dma_color_stage`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1 and `chan_type` is 0. The programmed mode, width and color and the working copies are all 0, so the block starts in pass-through at 8-bit width.
- R2: When the working mode is 00 (disabled) or 11 (reserved), each accepted element leaves with its data unchanged and `out_we` = 1.
- R3: When the working mode is 01 (constant fill), each accepted element leaves with the working color masked to the element width and `out_we` = 1, whatever the input data.
- R4: When the working mode is 10 (transparent copy), each accepted element leaves with its data unchanged. `out_we` is 0 when the element equals the key color at the element width, and 1 otherwise.
- R5: The element width is set by control bits [3:2]: 00 = 8 bits, 01 = 16 bits, 10 or 11 = 32 bits. Only the low bits at that width take part in fill masking and key comparison.
- R6: A register write to address 1 loads the low 16 bits of the color, and a write to address 2 loads the upper 16 bits. A write to address 0 loads the control word: mode in bits [1:0], width in bits [3:2].
- R7: Color writes to address 1 or 2 are ignored while the programmed mode is 00 or 11. Such a write leaves the stored color unchanged.
- R8: `chan_type` reads 1 (graphics) while the programmed mode is 01 or 10, and 0 (plain 2D) otherwise. It updates on the clock edge of the control write.
- R9: A control write replaces both mode bits together. Switching directly from fill to transparent copy never leaves any fill behaviour in place.
- R10: A pulse on `xfer_start` copies the programmed mode, width and color into the working set. Elements accepted after that edge use the new set, and later register writes do not change it until the next start pulse.
- R11: Each element is accepted when `in_valid && in_ready` and appears one cycle later. While `out_valid && !out_ready`, the output holds its data and qualifier. `in_ready` is 0 during a start cycle, and elements leave in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 color low, 2 color high |
| reg_wdata | input | 16 | Register write data |
| xfer_start | input | 1 | Starts a transfer; copies the configuration into the working set |
| chan_type | output | 4 | Channel type: 1 graphics, 0 plain 2D |
| in_valid | input | 1 | Input element valid |
| in_ready | output | 1 | Input element accepted when high together with valid |
| in_data | input | DATA_W | Input element, right-aligned |
| out_valid | output | 1 | Output element valid |
| out_ready | input | 1 | Write side can take the element |
| out_data | output | DATA_W | Output element |
| out_we | output | 1 | Write-enable qualifier for the output element |

## Verification
Suppose the working set were stale or captured at the wrong moment. The next element to leave after the start pulse would then carry the wrong data or qualifier, so a transfer that switches mode shows the fault within two cycles. A wrong width mask in fill mode shows as stray upper bits on the first fill element. In transparent mode it shows as a missed or extra suppression, which depends on feeding elements that match the key only in their low bits. A color write that was not gated by the mode shows only at the next fill transfer, so the bench fills straight after such a write.

// File: rtl/dma_color_stage.sv
module dma_color_stage #(
  parameter int DATA_W   = 32,
  parameter int HALF_W   = 16,
  parameter int TYPE_W   = 4,
  parameter logic [3:0] TYPE_GFX = 4'd1,
  parameter logic [3:0] TYPE_2D  = 4'd0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [HALF_W-1:0] reg_wdata,
  input  logic              xfer_start,
  output logic [TYPE_W-1:0] chan_type,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_we
);
  localparam logic [1:0] M_FILL = 2'b01;
  localparam logic [1:0] M_KEY  = 2'b10;

  logic [1:0]        stg_mode, stg_size, act_mode, act_size;
  logic [DATA_W-1:0] stg_color, act_color, mask, res_data;
  logic              stg_active, fire, key_hit, res_we;

  assign stg_active = (stg_mode == M_FILL) || (stg_mode == M_KEY);
  assign chan_type  = stg_active ? TYPE_GFX[TYPE_W-1:0] : TYPE_2D[TYPE_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_mode  <= '0;
      stg_size  <= '0;
      stg_color <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        2'd0: begin
          stg_mode <= reg_wdata[1:0];
          stg_size <= reg_wdata[3:2];
        end
        2'd1: if (stg_active) stg_color[HALF_W-1:0] <= reg_wdata;
        2'd2: if (stg_active) stg_color[DATA_W-1:HALF_W] <= reg_wdata[DATA_W-HALF_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_mode  <= '0;
      act_size  <= '0;
      act_color <= '0;
    end else if (xfer_start) begin
      act_mode  <= stg_mode;
      act_size  <= stg_size;
      act_color <= stg_color;
    end
  end

  always_comb begin
    case (act_size)
      2'b00:   mask = DATA_W'({8{1'b1}});
      2'b01:   mask = DATA_W'({16{1'b1}});
      default: mask = '1;
    endcase
  end

  assign key_hit  = ((in_data ^ act_color) & mask) == '0;
  assign res_data = (act_mode == M_FILL) ? (act_color & mask) : in_data;
  assign res_we   = !((act_mode == M_KEY) && key_hit);

  assign in_ready = !xfer_start && (!out_valid || out_ready);
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_we    <= 1'b0;
    end else if (fire) begin
      out_valid <= 1'b1;
      out_data  <= res_data;
      out_we    <= res_we;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

module dma_color_stage_chk #(
  parameter int DATA_W = 32,
  parameter int HALF_W = 16,
  parameter int TYPE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [1:0]        reg_addr,
  input logic [HALF_W-1:0] reg_wdata,
  input logic              xfer_start,
  input logic [TYPE_W-1:0] chan_type,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_data,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_we,
  input logic [1:0]        act_mode
);
  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_we));
  // R11
  start_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> !in_ready);
  // R2
  pass_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !act_mode[0] && !act_mode[1] |=> out_valid && out_we && out_data == $past(in_data));
  // R3
  fill_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && act_mode == 2'b01 |=> out_we);
  // R4
  drop_only_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && act_mode != 2'b10 |=> out_we);
  // R8
  type_gfx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == 2'd0 && (reg_wdata[1:0] == 2'b01 || reg_wdata[1:0] == 2'b10) |=> chan_type == 4'd1);
  // R8
  type_2d_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == 2'd0 && reg_wdata[1] == reg_wdata[0] |=> chan_type == 4'd0);
endmodule

bind dma_color_stage dma_color_stage_chk #(.DATA_W(DATA_W), .HALF_W(HALF_W), .TYPE_W(TYPE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .xfer_start(xfer_start), .chan_type(chan_type), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_we(out_we), .act_mode(act_mode)
);

// File: tb/dma_color_stage_tb.sv
`timescale 1ns/1ps
module dma_color_stage_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic        xfer_start = 1'b0;
  logic [3:0]  chan_type;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_data;
  logic        out_we;

  always #2.5 clk = ~clk;

  dma_color_stage dut_i (.*);

  int checks = 0, errors = 0;
  logic [1:0]  s_mode = '0, s_size = '0, a_mode = '0, a_size = '0;
  logic [31:0] s_color = '0, a_color = '0;
  logic        r10_win = 1'b0;
  logic [35:0] exp_q[$];
  logic        prev_stall = 1'b0, prev_we = 1'b0;
  logic [31:0] prev_data = '0;
  int          data_sel = 0;

  function automatic logic [31:0] wmask(input logic [1:0] sz);
    return (sz == 2'b00) ? 32'hFF : (sz == 2'b01) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [32:0] expect_elem(input logic [1:0] m, input logic [1:0] sz,
                                               input logic [31:0] col, input logic [31:0] d);
    if (m == 2'b01) return {1'b1, col & wmask(sz)};
    if (m == 2'b10) return {((d ^ col) & wmask(sz)) != 0, d};
    return {1'b1, d};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic st, input logic wr, input logic [1:0] ad, input logic [15:0] wd,
                     input logic v, input logic rdy);
    logic [35:0] e;
    @(negedge clk);
    xfer_start = st; reg_wr = wr; reg_addr = ad; reg_wdata = wd;
    in_valid = v; out_ready = rdy;
    case (data_sel)
      0: in_data = $urandom;
      default: in_data = ($urandom_range(0, 1) == 1) ? ((a_color & wmask(a_size)) | ($urandom & ~wmask(a_size)))
                                                       : $urandom;
    endcase
    #1;
    check("R8 chan_type", {28'd0, chan_type}, (s_mode == 2'b01 || s_mode == 2'b10) ? 32'd1 : 32'd0);
    if (st) check("R11 in_ready in start cycle", {31'd0, in_ready}, 32'd0);
    if (prev_stall) begin
      check("R11 stalled output held", {out_valid, out_we, out_data[29:0]}, {1'b1, prev_we, prev_data[29:0]});
    end
    prev_stall = out_valid && !out_ready;
    prev_we = out_we; prev_data = out_data;
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) check("R11 unexpected output", 32'd1, 32'd0);
      else begin
        e = exp_q.pop_front();
        check(e[35] ? "R10 data" : (e[34:33] == 2'b01) ? "R3 fill data" : (e[34:33] == 2'b10) ? "R4 key data" : "R2 pass data",
              out_data, e[31:0]);
        check(e[35] ? "R10 we" : (e[34:33] == 2'b10) ? "R4 key we" : "R2/R3 we", {31'd0, out_we}, {31'd0, e[32]});
      end
    end
    if (in_valid && in_ready) exp_q.push_back({r10_win, a_mode, expect_elem(a_mode, a_size, a_color, in_data)});
    @(posedge clk);
    if (st) begin a_mode = s_mode; a_size = s_size; a_color = s_color; end
    if (wr) begin
      if (ad == 2'd0) begin s_mode = wd[1:0]; s_size = wd[3:2]; end
      else if (s_mode == 2'b01 || s_mode == 2'b10) begin
        if (ad == 2'd1) s_color[15:0] = wd;
        else if (ad == 2'd2) s_color[31:16] = wd;
      end
    end
  endtask

  task automatic wreg(input logic [1:0] ad, input logic [15:0] wd);
    cyc(1'b0, 1'b1, ad, wd, 1'b0, 1'b1);
  endtask

  task automatic start();
    cyc(1'b1, 1'b0, 2'd0, 16'd0, 1'b1, 1'b1);
  endtask

  task automatic stream(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 2'd0, 16'd0, $urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0);
  endtask

  task automatic drain();
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0, 2'd0, 16'd0, 1'b0, 1'b1);
  endtask

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; #1;
    check("R1 out_valid", {31'd0, out_valid}, 32'd0);
    check("R1 in_ready", {31'd0, in_ready}, 32'd1);
    check("R1 chan_type", {28'd0, chan_type}, 32'd0);

    stream(40); drain();                               // R2 reset pass-through
    wreg(2'd0, 16'h000B); start(); stream(30); drain(); // R2 reserved mode 11, R8 type 0

    wreg(2'd0, 16'h0009);                               // fill, 32-bit
    wreg(2'd1, 16'hC3D4); wreg(2'd2, 16'hA1B2);         // R6
    start(); stream(20); drain();                       // R3
    wreg(2'd0, 16'h0005); start(); stream(15); drain(); // R5 16-bit fill
    wreg(2'd0, 16'h0001); start(); stream(15); drain(); // R5 8-bit fill

    wreg(2'd0, 16'h0000); wreg(2'd1, 16'h1111); wreg(2'd2, 16'h2222); // R7 ignored
    wreg(2'd0, 16'h0009); start(); stream(10); drain(); // R7 fill still A1B2C3D4

    wreg(2'd0, 16'h000A); start();                      // R9 fill -> key directly
    data_sel = 1; stream(40); drain();                  // R4 32-bit key
    wreg(2'd0, 16'h0002); start(); stream(40); drain(); // R5 8-bit key
    wreg(2'd0, 16'h0006); start(); stream(40); drain(); // R5 16-bit key
    data_sel = 0;

    wreg(2'd0, 16'h0009); start(); stream(5);           // R10 mid-transfer writes
    r10_win = 1'b1;
    wreg(2'd0, 16'h0000); stream(10); drain();
    r10_win = 1'b0;
    start(); stream(10); drain();                       // R10 new transfer is pass-through

    for (int k = 0; k < 30; k++) begin
      wreg(2'd0, {12'd0, 2'($urandom), 2'($urandom)});
      wreg(2'd1, 16'($urandom)); wreg(2'd2, 16'($urandom));
      data_sel = $urandom_range(0, 1);
      start(); stream($urandom_range(5, 40));
    end
    drain();
    check("R11 queue empty", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule